// File: doc/BRIEF.md
# Auto-Incrementing Buffer Pointer Unit

This unit generates the addresses for a host data port that reaches into packet buffer memory. The host programs a 16-bit pointer word through a small register port. The word carries an 11-bit byte offset and five mode bits. Each byte or word access on the data port is aimed at a buffer address made of a packet number and the current offset. The packet number comes from one of two sources. A mode bit picks the head of the receive queue or the transmit packet-number value. When auto-increment is on, the offset then steps past the bytes just moved.

In read mode, the unit asks memory for data ahead of the host. Loading the pointer issues a one-cycle prefetch request for the loaded address. Each auto-incrementing data-port read issues a request for the advanced address. Reading back the pointer returns the offset the host last touched, not the prefetch offset. An interrupt handler can therefore save the pointer and restore it without disturbing a transfer. A busy output stays high while write data may still be draining, and software waits for it to drop before it reloads the pointer.

Top module: `bptr_unit`

## Requirements
- R1: After reset, `ptr_rdata` is 0, `pf_req` is 0 and `wr_busy` is 0.
- R2: With auto-increment (pointer bit 12) set, a byte access (`dp_word`=0) advances the offset by 1. The next access address shows the advanced offset.
- R3: With auto-increment set, a word access (`dp_word`=1) advances the offset by 2.
- R4: With auto-increment clear, a data-port access leaves the offset unchanged and issues no prefetch.
- R5: The offset wraps modulo 2048. A word access at offset 0x7FE moves it to 0x000.
- R6: `acc_addr` is {packet, offset} with the offset in bits 10:0. The packet is `rxq_pkt` when receive-select (pointer bit 13) is 1, and `txq_pkt` when it is 0.
- R7: A pointer write that leaves the read bit (pointer bit 11) at 1 raises `pf_req` for exactly the next cycle. `pf_addr` then holds the loaded address. When the read bit is 0, no request is made.
- R8: In read mode with auto-increment set, a data-port read raises `pf_req` in the next cycle. `pf_addr` then holds the address at the advanced offset.
- R9: `ptr_rdata[10:0]` returns the offset of the last host access or pointer load, never the prefetch offset.
- R10: `ptr_be[0]` selects bits 7:0 and `ptr_be[1]` selects bits 15:8 of a pointer write. Lanes that are not selected keep their value.
- R11: A data-port write raises `wr_busy` for DRAIN_CYC cycles (default 4), after which it drops.
- R12: `ptr_rdata[15:11]` returns the mode bits as written: 15 auto-transmit, 14 early-transmit, 13 receive-select, 12 auto-increment, 11 read. A pointer write in the same cycle as a data-port access takes priority, and the access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_we | input | 1 | Pointer word write strobe |
| ptr_be | input | 2 | Byte-lane enables of the pointer write |
| ptr_wdata | input | 16 | Pointer write data |
| ptr_rdata | output | 16 | Pointer readback (mode bits, last accessed offset) |
| dp_rd | input | 1 | Data-port read access |
| dp_wr | input | 1 | Data-port write access |
| dp_word | input | 1 | Access size: 1 word, 0 byte |
| rxq_pkt | input | PNUM_W | Packet number at the receive queue head |
| txq_pkt | input | PNUM_W | Transmit packet-number value |
| acc_addr | output | PNUM_W+11 | Buffer address of the current access |
| pf_req | output | 1 | One-cycle prefetch read request |
| pf_addr | output | PNUM_W+11 | Prefetch read address |
| wr_busy | output | 1 | Write data may still be draining |

## Verification
A stimulus table first drives byte and word writes in write mode, which separates step 1 from step 2 and shows that no prefetch is made. It then drives reads in read mode that cross the 0x7FE boundary, which shows the wrap and places the prefetch offset and readback offset on different values. Partial-lane pointer writes in both byte-enable forms show that each lane is kept apart. A read with auto-increment off shows that the offset holds and no request is issued. Directed tests then cover reset, the live switch between the two packet sources, the length of the busy window, and a pointer write that collides with an access.

// File: rtl/bptr_pkg.sv
// Package: shared layout of the pointer word and the access-size type.
// Assumes a 16-bit pointer word with an 11-bit byte offset in the low bits.
package bptr_pkg;
    localparam int OFF_W   = 11;
    localparam int WORD_W  = 16;
    localparam int MODE_W  = WORD_W - OFF_W;
    localparam int LANES   = WORD_W / 8;

    // Mode bits in pointer-word order (bit 15 down to bit 11).
    typedef struct packed {
        logic auto_tx;
        logic early_tx;
        logic rx_sel;
        logic auto_inc;
        logic rd_mode;
    } mode_t;

    typedef struct packed {
        mode_t            mode;
        logic [OFF_W-1:0] off;
    } ptr_word_t;

    typedef enum logic {SZ_BYTE = 1'b0, SZ_WORD = 1'b1} acc_size_e;

    // Offset step for one access of the given size.
    function automatic logic [OFF_W-1:0] step_of(acc_size_e sz);
        return (sz == SZ_WORD) ? OFF_W'(2) : OFF_W'(1);
    endfunction
endpackage

// File: rtl/bptr_mode_reg.sv
// Mode register: holds the five mode bits and merges a byte-lane write
// into the current pointer word. Assumes the caller supplies the current
// host offset as the base for lanes that are not written.
module bptr_mode_reg
    import bptr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [LANES-1:0]    wr_be,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [OFF_W-1:0]    cur_off,
    output mode_t               mode_q,
    output ptr_word_t           merged
);
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] mix_word;

    // Present the stored word for lane merging.
    always_comb cur_word = {mode_q, cur_off};

    // Per-lane choice between written data and stored value.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb mix_word[g*8 +: 8] = wr_be[g] ? wr_data[g*8 +: 8]
                                                  : cur_word[g*8 +: 8];
    end

    // Expose the merged word to the offset and prefetch logic.
    always_comb merged = ptr_word_t'(mix_word);

    // Capture the mode bits on every pointer write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= merged.mode;
        end
    end
endmodule

// File: rtl/bptr_offset.sv
// Offset tracker: keeps the offset of the next access and the offset the
// host last accessed. A load sets both. An access records the offset it
// used and, with auto-increment, advances modulo 2**OFF_W.
// Assumes load and access are never both presented (top gives load priority).
module bptr_offset
    import bptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [OFF_W-1:0] load_off,
    input  logic             acc,
    input  acc_size_e        acc_sz,
    input  logic             auto_inc,
    output logic [OFF_W-1:0] next_off,
    output logic [OFF_W-1:0] host_off,
    output logic [OFF_W-1:0] adv_off
);
    // Advanced offset; natural overflow of OFF_W bits gives the wrap.
    always_comb adv_off = next_off + step_of(acc_sz);

    // Track the next and last-accessed offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_off <= '0;
            host_off <= '0;
        end else if (load) begin
            next_off <= load_off;
            host_off <= load_off;
        end else if (acc) begin
            host_off <= next_off;
            if (auto_inc) begin
                next_off <= adv_off;
            end
        end
    end
endmodule

// File: rtl/bptr_prefetch.sv
// Prefetch issuer: raises a one-cycle read request after a read-mode
// pointer load or an auto-incrementing read. Assumes both triggers are
// mutually exclusive in one cycle; a load takes precedence.
module bptr_prefetch #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_go,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step_go,
    input  logic [ADDR_W-1:0] step_addr,
    output logic              req,
    output logic [ADDR_W-1:0] addr
);
    // Register the request pulse and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            addr <= '0;
        end else begin
            req <= load_go | step_go;
            if (load_go) begin
                addr <= load_addr;
            end else if (step_go) begin
                addr <= step_addr;
            end
        end
    end
endmodule

// File: rtl/bptr_drain.sv
// Write drain timer: flags busy for DRAIN_CYC cycles after each data-port
// write. With DRAIN_CYC of 0 the flag is tied low.
module bptr_drain #(
    parameter int DRAIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_seen,
    output logic busy
);
    if (DRAIN_CYC == 0) begin : g_none
        always_comb busy = 1'b0;
    end else begin : g_cnt
        localparam int CNT_W = $clog2(DRAIN_CYC + 1);
        logic [CNT_W-1:0] cnt;

        // Reload on a write, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (wr_seen) begin
                cnt <= CNT_W'(DRAIN_CYC);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end

        // Busy while the window is open.
        always_comb busy = (cnt != '0);
    end
endmodule

// File: rtl/bptr_unit.sv
// Buffer pointer unit top. Forms data-port buffer addresses from a packet
// number and an auto-incrementing offset, issues read prefetches, and keeps
// a readback of the last host-accessed offset.
// Assumes the host never asserts dp_rd and dp_wr together; a pointer
// write in the same cycle as an access wins and the access is dropped.
module bptr_unit
    import bptr_pkg::*;
#(
    parameter int PNUM_W    = 6,
    parameter int DRAIN_CYC = 4,
    localparam int ADDR_W   = PNUM_W + bptr_pkg::OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic [1:0]        ptr_be,
    input  logic [15:0]       ptr_wdata,
    output logic [15:0]       ptr_rdata,
    input  logic              dp_rd,
    input  logic              dp_wr,
    input  logic              dp_word,
    input  logic [PNUM_W-1:0] rxq_pkt,
    input  logic [PNUM_W-1:0] txq_pkt,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              pf_req,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              wr_busy
);
    mode_t             mode_q;
    ptr_word_t         merged;
    logic [OFF_W-1:0]  next_off;
    logic [OFF_W-1:0]  host_off;
    logic [OFF_W-1:0]  adv_off;
    logic              acc;
    acc_size_e         acc_sz;
    logic [PNUM_W-1:0] pkt_now;
    logic [PNUM_W-1:0] pkt_load;
    logic              load_go;
    logic              step_go;

    // Accesses count only when no pointer write claims the cycle.
    always_comb acc    = (dp_rd | dp_wr) & ~ptr_we;
    always_comb acc_sz = acc_size_e'(dp_word);

    // Packet source for the current mode and for a mode being loaded.
    always_comb pkt_now  = mode_q.rx_sel ? rxq_pkt : txq_pkt;
    always_comb pkt_load = merged.mode.rx_sel ? rxq_pkt : txq_pkt;

    // Prefetch triggers: read-mode load, or auto-incrementing read.
    always_comb load_go = ptr_we & merged.mode.rd_mode;
    always_comb step_go = dp_rd & ~ptr_we & mode_q.rd_mode & mode_q.auto_inc;

    // Outward address and readback views.
    always_comb acc_addr  = {pkt_now, next_off};
    always_comb ptr_rdata = {mode_q, host_off};

    bptr_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ptr_we),
        .wr_be   (ptr_be),
        .wr_data (ptr_wdata),
        .cur_off (host_off),
        .mode_q  (mode_q),
        .merged  (merged)
    );

    bptr_offset u_off (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_we),
        .load_off (merged.off),
        .acc      (acc),
        .acc_sz   (acc_sz),
        .auto_inc (mode_q.auto_inc),
        .next_off (next_off),
        .host_off (host_off),
        .adv_off  (adv_off)
    );

    bptr_prefetch #(.ADDR_W(ADDR_W)) u_pf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_go   (load_go),
        .load_addr ({pkt_load, merged.off}),
        .step_go   (step_go),
        .step_addr ({pkt_now, adv_off}),
        .req       (pf_req),
        .addr      (pf_addr)
    );

    bptr_drain #(.DRAIN_CYC(DRAIN_CYC)) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_seen (dp_wr & ~ptr_we),
        .busy    (wr_busy)
    );
endmodule

// File: rtl/bptr_unit_chk.sv
// Checker for bptr_unit: port-level temporal properties, bound to the top.
module bptr_unit_chk #(
    parameter int PNUM_W    = 6,
    parameter int DRAIN_CYC = 4,
    localparam int ADDR_W   = PNUM_W + 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_we,
    input logic [1:0]        ptr_be,
    input logic [15:0]       ptr_wdata,
    input logic [15:0]       ptr_rdata,
    input logic              dp_rd,
    input logic              dp_wr,
    input logic              dp_word,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              pf_req,
    input logic              wr_busy
);
    a_r2_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && (dp_rd || dp_wr) && !dp_word && ptr_rdata[12])
        |=> acc_addr[10:0] == 11'($past(acc_addr[10:0]) + 11'd1));

    a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && (dp_rd || dp_wr) && dp_word && ptr_rdata[12])
        |=> acc_addr[10:0] == 11'($past(acc_addr[10:0]) + 11'd2));

    a_r4_hold_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && (dp_rd || dp_wr) && !ptr_rdata[12])
        |=> $stable(acc_addr[10:0]) && !pf_req);

    a_r7_load_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && ptr_be[1] && ptr_wdata[11]) |=> pf_req);

    a_r7_load_no_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && ptr_be[1] && !ptr_wdata[11]) |=> !pf_req);

    a_r8_pf_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req |-> ptr_rdata[11]);

    a_r9_readback_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_we && (dp_rd || dp_wr)) |=> ptr_rdata[10:0] == $past(acc_addr[10:0]));

    a_r11_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (DRAIN_CYC > 0 && dp_wr && !ptr_we) |=> wr_busy);
endmodule

bind bptr_unit bptr_unit_chk #(.PNUM_W(PNUM_W), .DRAIN_CYC(DRAIN_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_we    (ptr_we),
    .ptr_be    (ptr_be),
    .ptr_wdata (ptr_wdata),
    .ptr_rdata (ptr_rdata),
    .dp_rd     (dp_rd),
    .dp_wr     (dp_wr),
    .dp_word   (dp_word),
    .acc_addr  (acc_addr),
    .pf_req    (pf_req),
    .wr_busy   (wr_busy)
);

// File: tb/test_bptr_unit.sv
`timescale 1ns/1ps
module test_bptr_unit;
    localparam int PNUM_W = 6;
    localparam int ADDR_W = PNUM_W + 11;
    localparam int DRAIN  = 4;
    localparam logic [PNUM_W-1:0] RXP = 6'h15;
    localparam logic [PNUM_W-1:0] TXP = 6'h2A;

    localparam logic [2:0] OP_REG = 3'd0, OP_BRD = 3'd1, OP_WRD = 3'd2,
                           OP_BWR = 3'd3, OP_WWR = 3'd4;

    typedef struct packed {
        logic [3:0]        req;
        logic [2:0]        op;
        logic [15:0]       data;
        logic [1:0]        be;
        logic              chk_acc;
        logic [ADDR_W-1:0] exp_acc;
        logic [15:0]       exp_rb;
        logic              exp_pf;
        logic [ADDR_W-1:0] exp_pfa;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{4'd12, OP_REG, 16'h1100, 2'b11, 1'b0, '0,               16'h1100, 1'b0, '0},               // R12 load, R7 no pf
        '{4'd2,  OP_BWR, 16'h0000, 2'b00, 1'b1, {TXP, 11'h100},   16'h1100, 1'b0, '0},               // R2 R6
        '{4'd3,  OP_WWR, 16'h0000, 2'b00, 1'b1, {TXP, 11'h101},   16'h1101, 1'b0, '0},               // R3
        '{4'd2,  OP_BWR, 16'h0000, 2'b00, 1'b1, {TXP, 11'h103},   16'h1103, 1'b0, '0},               // R2
        '{4'd7,  OP_REG, 16'h3FFE, 2'b11, 1'b0, '0,               16'h3FFE, 1'b1, {RXP, 11'h7FE}},   // R7
        '{4'd5,  OP_WRD, 16'h0000, 2'b00, 1'b1, {RXP, 11'h7FE},   16'h3FFE, 1'b1, {RXP, 11'h000}},   // R5 R8 R9
        '{4'd8,  OP_BRD, 16'h0000, 2'b00, 1'b1, {RXP, 11'h000},   16'h3800, 1'b1, {RXP, 11'h001}},   // R8
        '{4'd10, OP_REG, 16'h0005, 2'b01, 1'b0, '0,               16'h3805, 1'b1, {RXP, 11'h005}},   // R10 low lane
        '{4'd6,  OP_REG, 16'h0810, 2'b11, 1'b0, '0,               16'h0810, 1'b1, {TXP, 11'h010}},   // R6 tx source
        '{4'd4,  OP_BRD, 16'h0000, 2'b00, 1'b1, {TXP, 11'h010},   16'h0810, 1'b0, '0},               // R4
        '{4'd10, OP_REG, 16'hC0AA, 2'b10, 1'b0, '0,               16'hC010, 1'b0, '0}                // R10 high lane
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ptr_we;
    logic [1:0]        ptr_be;
    logic [15:0]       ptr_wdata;
    logic [15:0]       ptr_rdata;
    logic              dp_rd, dp_wr, dp_word;
    logic [PNUM_W-1:0] rxq_pkt, txq_pkt;
    logic [ADDR_W-1:0] acc_addr, pf_addr;
    logic              pf_req, wr_busy;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bptr_unit #(.PNUM_W(PNUM_W), .DRAIN_CYC(DRAIN)) i_bptr_unit (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_be(ptr_be),
        .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata), .dp_rd(dp_rd),
        .dp_wr(dp_wr), .dp_word(dp_word), .rxq_pkt(rxq_pkt), .txq_pkt(txq_pkt),
        .acc_addr(acc_addr), .pf_req(pf_req), .pf_addr(pf_addr), .wr_busy(wr_busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ptr_we = 1'b0; ptr_be = 2'b00; ptr_wdata = '0;
        dp_rd = 1'b0; dp_wr = 1'b0; dp_word = 1'b0;
    endtask

    // Drive one operation at a negedge; returns at the next negedge.
    task automatic drive(input logic [2:0] op, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        idle();
        case (op)
            OP_REG: begin ptr_we = 1'b1; ptr_wdata = d; ptr_be = be; end
            OP_BRD: dp_rd = 1'b1;
            OP_WRD: begin dp_rd = 1'b1; dp_word = 1'b1; end
            OP_BWR: dp_wr = 1'b1;
            OP_WWR: begin dp_wr = 1'b1; dp_word = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n   = 1'b0;
        rxq_pkt = RXP;
        txq_pkt = TXP;
        do_reset();

        // R1: reset state
        check("R1 rdata", 32'(ptr_rdata), 32'h0);
        check("R1 pf_req", 32'(pf_req), 32'h0);
        check("R1 busy", 32'(wr_busy), 32'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].op, VEC[i].data, VEC[i].be);
            #1;
            if (VEC[i].chk_acc)
                check($sformatf("R%0d vec%0d acc_addr", VEC[i].req, i), 32'(acc_addr), 32'(VEC[i].exp_acc));
            @(negedge clk);
            idle();
            check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), 32'(ptr_rdata), 32'(VEC[i].exp_rb));
            check($sformatf("R%0d vec%0d pf_req", VEC[i].req, i), 32'(pf_req), 32'(VEC[i].exp_pf));
            if (VEC[i].exp_pf)
                check($sformatf("R%0d vec%0d pf_addr", VEC[i].req, i), 32'(pf_addr), 32'(VEC[i].exp_pfa));
        end

        // R11: busy window after one write
        do_reset();
        drive(OP_BWR, 16'h0, 2'b00);
        @(negedge clk);
        idle();
        check("R11 busy cycle1", 32'(wr_busy), 32'h1);
        repeat (DRAIN - 1) @(negedge clk);
        check("R11 busy last", 32'(wr_busy), 32'h1);
        @(negedge clk);
        check("R11 busy cleared", 32'(wr_busy), 32'h0);

        // R6: receive source follows the queue head live
        drive(OP_REG, 16'h2040, 2'b11);
        @(negedge clk);
        idle();
        rxq_pkt = 6'h33;
        #1;
        check("R6 rx head live", 32'(acc_addr), 32'({6'h33, 11'h040}));
        rxq_pkt = RXP;

        // R12: pointer write beats a colliding access
        drive(OP_REG, 16'h1200, 2'b11);
        dp_wr = 1'b1;
        @(negedge clk);
        idle();
        check("R12 collide rdata", 32'(ptr_rdata), 32'h1200);
        check("R12 collide busy", 32'(wr_busy), 32'h0);
        #1;
        check("R12 collide acc", 32'(acc_addr), 32'({TXP, 11'h200}));

        // R1: reset mid-run clears the pointer again
        do_reset();
        check("R1 rdata after rerun", 32'(ptr_rdata), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule